// File: doc/BRIEF.md
# Command/Address Deserializer with Mode Register File

This block sits behind a five-pin command/address port and turns the beat stream into decoded commands. It is clocked once per beat, i.e. at twice the command clock. Every four beats form one 20-bit slot. Two bits of each slot carry its own integrity: an inversion flag and an even-parity bit. The block undoes the inversion, checks the parity, and drops any slot that fails. It then reports each accepted command as a one-cycle valid pulse with an opcode and a field word.

A mode-register write is a two-slot command. Its payload rides only on the row pins (0 to 2) of its eight beats. When both slots are accepted, the block writes a 12-bit value into one of 64 mode registers. Addresses 32 to 47 form a reserved window: nothing is stored there, and those addresses always read as zero. A combinational read port lets the rest of the device see the register contents. A frame-sync input marks beat 0 and realigns the beat counter. Nothing else realigns it.

Top module: `ca_deser`

## Requirements
- R1: Slot bit 5*b+p is pin p of beat b (b = 0..3). The decoded result appears on the outputs one clock after beat 3 is sampled, for exactly one cycle.
- R2: The beat on which sync_i is high is taken as beat 0 of a new slot. Any partly collected slot is discarded.
- R3: A slot is accepted only if the XOR of all 20 raw bits is 0. A rejected slot gives no cmd_valid_o and a one-cycle par_err_o pulse, at the same cycle an accepted command would appear.
- R4: A parity error leaves the beat count running. The slot that follows a rejected one, sent without sync_i, is decoded normally.
- R5: Bit 18 is the inversion flag and bit 19 is the parity bit. When bit 18 is 1, bits 17..0 are complemented before decoding. Parity is always computed on the raw bits.
- R6: An accepted single-slot command has an opcode from decoded bits 2..0 (values 0 to 6). It shows cmd_op_o equal to that opcode and cmd_field_o equal to decoded bits 17..3, zero-extended to 18 bits.
- R7: Opcode 7 opens a mode-register write and gives no output pulse. The row bits of the slot are r[11:0], with r[3b+k] = bit 5b+k. The address is r1[8:3] of the first slot. The data is {r2[8:0], r1[11:9]}, where r2 is from the next slot. When the second slot is accepted, the register is written and cmd_valid_o pulses with op 7 and field {data, address}.
- R8: A parity error in either slot of a mode-register write cancels it. No register is written. After an error in the second slot, the next slot starts a new command.
- R9: Writes to addresses 32 to 47 are ignored, and those addresses always read 0.
- R10: After reset every register reads 0. A write to any address outside the reserved window, including 48 to 63, is read back unchanged.
- R11: mr_rdata_o follows mr_raddr_i combinationally. A write is visible from the clock edge that completes the second slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock (two beats per command clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Marks the current beat as beat 0 |
| ca_i | input | 5 | Command/address pins: 0..2 row, 3..4 column |
| cmd_valid_o | output | 1 | One-cycle pulse per accepted command |
| cmd_op_o | output | 3 | Opcode of the reported command |
| cmd_field_o | output | 18 | Command field or {data, address} of a register write |
| par_err_o | output | 1 | One-cycle pulse per slot rejected by parity |
| mr_raddr_i | input | 6 | Mode register read address |
| mr_rdata_o | output | 12 | Mode register read data |

## Verification
The bench builds the block with its default reserved window of 32 to 47. Directed register writes land on both edges of the window (31, 32, 47, 48) as well as on ordinary and vendor-range addresses, and a final sweep reads all 64 registers. Several hundred random back-to-back slots follow the directed cases, with random inversion, occasional bad parity and about one opcode-7 slot in eight. These slots reach cases that directed tests hardly touch: consecutive register writes, a register write whose second slot itself carries opcode 7, and parity errors that split a pair.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int CA_PINS  = 5;
  localparam int CA_BEATS = 4;
  localparam int CA_ROWS  = 3;
  localparam int CW       = CA_PINS * CA_BEATS;
  localparam int DW       = CW - 2;              // payload bits below flag and parity
  localparam int INV_BIT  = CW - 2;
  localparam int ROW_W    = CA_ROWS * CA_BEATS;
  localparam int MRA_W    = 6;
  localparam int MRD_W    = 12;
  localparam int OP_W     = CA_ROWS;
  localparam int FIELD_W  = MRA_W + MRD_W;
  localparam logic [OP_W-1:0] OP_MRS = '1;

  // even parity over the raw slot
  function automatic logic parity_ok(input logic [CW-1:0] w);
    return ~(^w);
  endfunction

  // restore payload when the inversion flag is set
  function automatic logic [DW-1:0] undo_inv(input logic [CW-1:0] w);
    return w[INV_BIT] ? ~w[DW-1:0] : w[DW-1:0];
  endfunction

  // gather the row pins of every beat into one vector
  function automatic logic [ROW_W-1:0] row_bits(input logic [DW-1:0] d);
    logic [ROW_W-1:0] rb;
    for (int b = 0; b < CA_BEATS; b++)
      for (int r = 0; r < CA_ROWS; r++)
        rb[b*CA_ROWS + r] = d[b*CA_PINS + r];
    return rb;
  endfunction
endpackage

// File: rtl/ca_beat_gather.sv
module ca_beat_gather
  import ca_pkg::*;
#(
  parameter int PINS  = CA_PINS,
  parameter int BEATS = CA_BEATS,
  localparam int W    = PINS * BEATS,
  localparam int IW   = $clog2(BEATS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_i,
  input  logic [PINS-1:0] ca_i,
  output logic [W-1:0]    word_o,
  output logic            done_o
);
  logic [IW-1:0]             cnt;
  logic [IW-1:0]             idx;
  logic [PINS*(BEATS-1)-1:0] sh;

  assign idx    = sync_i ? '0 : cnt;
  assign done_o = (idx == IW'(BEATS-1));
  assign word_o = {ca_i, sh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else begin
      cnt <= done_o ? '0 : idx + 1'b1;
      for (int b = 0; b < BEATS-1; b++)
        if (idx == IW'(b)) sh[b*PINS +: PINS] <= ca_i;
    end
  end

  // R2: a sync beat is beat 0, so the following beat is beat 1
  p_sync_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (cnt == IW'(1)));

  // R1: slot completion never happens on two beats in a row
  p_slot_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/ca_word_check.sv
module ca_word_check
  import ca_pkg::*;
(
  input  logic [CW-1:0] word_i,
  output logic          par_ok_o,
  output logic [DW-1:0] dec_o
);
  assign par_ok_o = parity_ok(word_i);
  assign dec_o    = undo_inv(word_i);
endmodule

// File: rtl/ca_cmd_decode.sv
module ca_cmd_decode
  import ca_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done_i,
  input  logic               par_ok_i,
  input  logic [DW-1:0]      dec_i,
  output logic               cmd_valid_o,
  output logic [OP_W-1:0]    cmd_op_o,
  output logic [FIELD_W-1:0] cmd_field_o,
  output logic               par_err_o,
  output logic               mr_we_o,
  output logic [MRA_W-1:0]   mr_waddr_o,
  output logic [MRD_W-1:0]   mr_wdata_o
);
  localparam int HOLD_W = ROW_W - CA_ROWS;
  localparam int LOW_D  = HOLD_W - MRA_W;       // data bits taken from first slot

  logic [ROW_W-1:0]  rows;
  logic              pend;
  logic [HOLD_W-1:0] hold;
  logic              slot_ok;
  logic              opens_mrs;

  assign rows       = row_bits(dec_i);
  assign slot_ok    = done_i && par_ok_i;
  assign opens_mrs  = slot_ok && !pend && (rows[OP_W-1:0] == OP_MRS);
  assign mr_we_o    = slot_ok && pend;
  assign mr_waddr_o = hold[MRA_W-1:0];
  assign mr_wdata_o = {rows[MRD_W-LOW_D-1:0], hold[HOLD_W-1:MRA_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= '0;
      cmd_field_o <= '0;
      par_err_o   <= 1'b0;
      pend        <= 1'b0;
      hold        <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      par_err_o   <= 1'b0;
      if (done_i) begin
        if (!par_ok_i) begin
          par_err_o <= 1'b1;
          pend      <= 1'b0;
        end else if (pend) begin
          cmd_valid_o <= 1'b1;
          cmd_op_o    <= OP_MRS;
          cmd_field_o <= {mr_wdata_o, mr_waddr_o};
          pend        <= 1'b0;
        end else if (opens_mrs) begin
          pend <= 1'b1;
          hold <= rows[ROW_W-1:CA_ROWS];
        end else begin
          cmd_valid_o <= 1'b1;
          cmd_op_o    <= rows[OP_W-1:0];
          cmd_field_o <= FIELD_W'(dec_i[DW-1:OP_W]);
        end
      end
    end
  end

  // R3: a rejected slot raises the error pulse and never a command
  p_err_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !par_ok_i) |=> (par_err_o && !cmd_valid_o));

  // R1: outputs only pulse right after a completed slot
  p_valid_after_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o || par_err_o) |-> $past(done_i));

  // R7: the first half of a register write reports nothing
  p_first_half_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    opens_mrs |=> (!cmd_valid_o && !par_err_o));

  // R8: a write strobe is always paired with an accepted slot after an opener
  p_write_needs_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mr_we_o |=> (cmd_valid_o && cmd_op_o == OP_MRS));
endmodule

// File: rtl/ca_mode_regs.sv
module ca_mode_regs
  import ca_pkg::*;
#(
  parameter int AW     = MRA_W,
  parameter int RW     = MRD_W,
  parameter int RSV_LO = 32,
  parameter int RSV_HI = 47,
  localparam int N     = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [RW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [RW-1:0] rdata_o
);
  logic [N-1:0][RW-1:0] q;

  function automatic logic in_rsv(input logic [AW-1:0] a);
    return (int'(a) >= RSV_LO) && (int'(a) <= RSV_HI);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        if (we_i && waddr_i == AW'(i) && !in_rsv(AW'(i))) q[i] <= wdata_i;
    end
  end

  assign rdata_o = in_rsv(raddr_i) ? '0 : q[raddr_i];

  // R9: the reserved window reads zero
  p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_rsv(raddr_i) |-> (rdata_o == '0));

  // R10: a write outside the window is seen on the next read of that address
  p_write_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !in_rsv(waddr_i) && waddr_i == raddr_i)
      |=> ((raddr_i != $past(raddr_i)) || (rdata_o == $past(wdata_i))));
endmodule

// File: rtl/ca_deser.sv
module ca_deser
  import ca_pkg::*;
#(
  parameter int RSV_LO = 32,
  parameter int RSV_HI = 47
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_i,
  input  logic [CA_PINS-1:0] ca_i,
  output logic               cmd_valid_o,
  output logic [OP_W-1:0]    cmd_op_o,
  output logic [FIELD_W-1:0] cmd_field_o,
  output logic               par_err_o,
  input  logic [MRA_W-1:0]   mr_raddr_i,
  output logic [MRD_W-1:0]   mr_rdata_o
);
  logic [CW-1:0]    slot_word;
  logic             slot_done;
  logic             slot_par_ok;
  logic [DW-1:0]    slot_dec;
  logic             mr_we;
  logic [MRA_W-1:0] mr_waddr;
  logic [MRD_W-1:0] mr_wdata;

  ca_beat_gather #(.PINS(CA_PINS), .BEATS(CA_BEATS)) i_gather (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .ca_i(ca_i),
    .word_o(slot_word), .done_o(slot_done)
  );

  ca_word_check i_check (
    .word_i(slot_word), .par_ok_o(slot_par_ok), .dec_o(slot_dec)
  );

  ca_cmd_decode i_decode (
    .clk(clk), .rst_n(rst_n), .done_i(slot_done), .par_ok_i(slot_par_ok),
    .dec_i(slot_dec), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
    .cmd_field_o(cmd_field_o), .par_err_o(par_err_o), .mr_we_o(mr_we),
    .mr_waddr_o(mr_waddr), .mr_wdata_o(mr_wdata)
  );

  ca_mode_regs #(.AW(MRA_W), .RW(MRD_W), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) i_regs (
    .clk(clk), .rst_n(rst_n), .we_i(mr_we), .waddr_i(mr_waddr),
    .wdata_i(mr_wdata), .raddr_i(mr_raddr_i), .rdata_o(mr_rdata_o)
  );
endmodule

// File: tb/test_ca_deser.sv
module test_ca_deser;
  localparam int TCLK = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic [4:0]  ca_i = '0;
  logic        cmd_valid_o;
  logic [2:0]  cmd_op_o;
  logic [17:0] cmd_field_o;
  logic        par_err_o;
  logic [5:0]  mr_raddr_i = '0;
  logic [11:0] mr_rdata_o;

  ca_deser i_ca_deser (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .ca_i(ca_i),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_field_o(cmd_field_o),
    .par_err_o(par_err_o), .mr_raddr_i(mr_raddr_i), .mr_rdata_o(mr_rdata_o)
  );

  always #(TCLK/2) clk = ~clk;

  int          n_vec = 0;
  int          n_bad = 0;
  logic [11:0] mem_m [64];
  bit          pend_m = 0;
  logic [8:0]  hold_m = '0;
  bit          have_prev = 0;
  bit          e_valid, e_err;
  logic [2:0]  e_op;
  logic [17:0] e_field;
  string       e_req;

  function automatic bit rsv(input logic [5:0] a);
    return a >= 6'd32 && a <= 6'd47;
  endfunction

  function automatic logic [17:0] logical(input logic [11:0] rows, input logic [5:0] cols);
    logic [17:0] lg;
    lg = '0;
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 3; r++) lg[5*b + r] = rows[3*b + r];
    for (int b = 0; b < 3; b++)
      for (int c = 0; c < 2; c++) lg[5*b + 3 + c] = cols[2*b + c];
    return lg;
  endfunction

  function automatic logic [19:0] build(input logic [17:0] lg, input bit inv, input bit bad);
    logic [19:0] raw;
    raw[17:0] = inv ? ~lg : lg;
    raw[18]   = inv;
    raw[19]   = (^raw[18:0]) ^ bad;
    return raw;
  endfunction

  task automatic check_prev();
    if (have_prev) begin
      n_vec++;
      if (cmd_valid_o !== e_valid || par_err_o !== e_err ||
          (e_valid && (cmd_op_o !== e_op || cmd_field_o !== e_field))) begin
        n_bad++;
        $display("FAIL %s: got v=%0b e=%0b op=%0d f=%h, expected v=%0b e=%0b op=%0d f=%h",
                 e_req, cmd_valid_o, par_err_o, cmd_op_o, cmd_field_o,
                 e_valid, e_err, e_op, e_field);
      end
    end
  endtask

  task automatic send_slot(input logic [11:0] rows, input logic [5:0] cols,
                           input bit inv, input bit bad, input bit sy, input string req);
    logic [17:0] lg;
    logic [19:0] raw;
    bit v, er;
    logic [2:0]  op;
    logic [17:0] fld;
    logic [5:0]  a;
    logic [11:0] d;
    lg = logical(rows, cols);
    raw = build(lg, inv, bad);
    v = 0; er = 0; op = '0; fld = '0;
    if (bad) begin
      er = 1; pend_m = 0;
    end else if (pend_m) begin
      a = hold_m[5:0];
      d = {rows[8:0], hold_m[8:6]};
      if (!rsv(a)) mem_m[a] = d;
      v = 1; op = 3'd7; fld = {d, a}; pend_m = 0;
    end else if (rows[2:0] == 3'd7) begin
      pend_m = 1; hold_m = rows[11:3];
    end else begin
      v = 1; op = rows[2:0]; fld = {3'b000, lg[17:3]};
    end
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      if (b == 0) begin
        check_prev();
        have_prev = 1; e_valid = v; e_err = er; e_op = op; e_field = fld; e_req = req;
      end
      ca_i = raw[5*b +: 5];
      sync_i = (b == 0) && sy;
    end
  endtask

  task automatic send_mrs(input logic [5:0] a, input logic [11:0] d,
                          input bit inv1, input bit inv2, input bit bad2, input string req);
    send_slot({d[2:0], a, 3'b111}, 6'($urandom), inv1, 1'b0, 1'b0, req);
    send_slot({3'($urandom), d[11:3]}, 6'($urandom), inv2, bad2, 1'b0, req);
  endtask

  task automatic flush();
    @(negedge clk);
    check_prev();
    have_prev = 0;
    ca_i = '0;
    sync_i = 1'b0;
  endtask

  task automatic read_chk(input logic [5:0] a, input logic [11:0] exp, input string req);
    mr_raddr_i = a;
    #1;
    n_vec++;
    if (mr_rdata_o !== exp) begin
      n_bad++;
      $display("FAIL %s: read addr %0d got %h, expected %h", req, a, mr_rdata_o, exp);
    end
  endtask

  initial begin
    #(TCLK * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    n_vec++;
    if (cmd_valid_o !== 1'b0 || par_err_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: reset outputs v=%0b e=%0b, expected 0 0", cmd_valid_o, par_err_o);
    end
    read_chk(6'd0, 12'h000, "R10 reset");
    read_chk(6'd63, 12'h000, "R10 reset");

    // R1 R6 plain command, R5 inverted command
    send_slot(12'b101_011_110_011, 6'b10_01_11, 1'b0, 1'b0, 1'b1, "R1 R6 plain");
    send_slot(12'b010_111_001_101, 6'b01_10_00, 1'b1, 1'b0, 1'b0, "R5 inverted");
    send_slot(12'b111_111_111_110, 6'b11_11_11, 1'b1, 1'b0, 1'b0, "R5 R6 op6 inverted");
    // R3 bad parity, then R4 next slot without sync
    send_slot(12'b000_000_000_010, 6'b00_00_01, 1'b0, 1'b1, 1'b0, "R3 bad parity");
    send_slot(12'b110_001_100_001, 6'b00_11_01, 1'b0, 1'b0, 1'b0, "R4 after error");
    send_slot(12'b000_000_000_000, 6'b00_00_00, 1'b1, 1'b1, 1'b0, "R3 R5 bad inverted");
    send_slot(12'b011_011_011_100, 6'b10_10_10, 1'b0, 1'b0, 1'b0, "R4 after error");

    // R7 register writes, R9 reserved window, R10 vendor range
    send_mrs(6'd5,  12'hA5C, 1'b0, 1'b0, 1'b0, "R7 write 5");
    send_mrs(6'd31, 12'h3F1, 1'b1, 1'b0, 1'b0, "R7 write 31");
    send_mrs(6'd32, 12'hFFF, 1'b0, 1'b1, 1'b0, "R9 write 32");
    send_mrs(6'd47, 12'h123, 1'b1, 1'b1, 1'b0, "R9 write 47");
    send_mrs(6'd48, 12'h8E7, 1'b0, 1'b0, 1'b0, "R10 write 48");
    send_mrs(6'd60, 12'h5A5, 1'b1, 1'b0, 1'b0, "R10 write 60");
    // R8 error in second slot, then error in first slot
    send_mrs(6'd9,  12'hBEE, 1'b0, 1'b0, 1'b1, "R8 second slot bad");
    send_slot({3'b001, 6'd10, 3'b111}, 6'b000000, 1'b0, 1'b1, 1'b0, "R8 first slot bad");
    send_slot(12'b000_000_000_011, 6'b01_00_10, 1'b0, 1'b0, 1'b0, "R8 R6 next command");

    // R2 partial slot discarded by sync
    flush();
    ca_i = 5'b10101;
    @(negedge clk); ca_i = 5'b01110;
    @(negedge clk); ca_i = 5'b11001;
    send_slot(12'b100_010_001_010, 6'b11_00_11, 1'b0, 1'b0, 1'b1, "R2 sync realign");
    send_slot(12'b001_010_100_000, 6'b01_01_01, 1'b1, 1'b0, 1'b0, "R2 following slot");
    flush();

    // R11 R7 R9 R10 R8 read back
    read_chk(6'd5,  12'hA5C, "R11 R7 read 5");
    read_chk(6'd31, 12'h3F1, "R7 read 31");
    read_chk(6'd32, 12'h000, "R9 read 32");
    read_chk(6'd47, 12'h000, "R9 read 47");
    read_chk(6'd48, 12'h8E7, "R10 read 48");
    read_chk(6'd60, 12'h5A5, "R10 read 60");
    read_chk(6'd9,  12'h000, "R8 read 9");
    read_chk(6'd10, 12'h000, "R8 read 10");

    // random mix: R1 R3 R4 R5 R6 R7 R8
    send_slot(12'h000, 6'h00, 1'b0, 1'b0, 1'b1, "R2 R6 resync");
    for (int i = 0; i < 400; i++) begin
      send_slot(12'($urandom), 6'($urandom), 1'($urandom), ($urandom % 8) == 0,
                1'b0, "R1 R3 R5 R6 R7 R8 random");
    end
    send_slot({9'($urandom), 3'b000}, 6'($urandom), 1'b0, 1'b0, 1'b0, "R6 R7 closing");
    flush();
    for (int a = 0; a < 64; a++) read_chk(6'(a), mem_m[a], "R9 R10 R11 sweep");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule